// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block sits on the host side of a string of serial sampling converters. The converters share one convert strobe and one serial clock, and each device's data output feeds the data input of the next. The controller makes both shared lines from the system clock. When the user asks for a sample set, it raises the convert strobe while the serial clock is held high, which puts the devices into chained mode with a completion flag. It then waits for the data line of the nearest device to go high, because that edge means every converter in the chain has finished.

Readback follows the completion edge. The controller issues one serial clock more than the total number of data bits and samples the data line at every falling edge. The first sampled bit is the completion flag and drops out. The remaining bits form one 16-bit word per device in arrival order. That concatenated word set goes to the user as a valid/ready output and stays there until the user accepts it. If no completion edge arrives within a bounded time, the controller signals a timeout and abandons the cycle. After each cycle it keeps the convert strobe low for a minimum acquisition interval. The chain length, word width, serial clock divider, timeout and acquisition interval are parameters.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is high, and on the first clock after it, `cnv_o`=0, `sck_o`=1, `m_valid`=0 and `timeout_o`=0.
- R2: `cnv_o` rises only when `start` is high, no cycle is in progress, no result is pending and the acquisition interval has passed. When it rises, `sck_o` is high.
- R3: `sck_o` is low only while `cnv_o` is high. `cnv_o` stays high from its rise through the conversion wait and the entire readback.
- R4: Readback begins only on a low-to-high transition of `sdo_in` seen while converting. Exactly N_DEV*WORD_W+1 falling edges of `sck_o` are issued per completed cycle.
- R5: `sdo_in` is sampled at each falling edge of `sck_o`, taking the value present just before the edge, and the first sample is discarded. The word arriving k-th (k=0 is the nearest device), MSB first, lands in `m_data[WORD_W*(N_DEV-k)-1 -: WORD_W]`.
- R6: `m_valid` rises in the same cycle that `cnv_o` falls after a completed readback. It then holds, with `m_data` unchanged, until a cycle with `m_ready` high, and is low in the cycle after that handshake.
- R7: If no rise of `sdo_in` is seen within TIMEOUT_CYC cycles of `cnv_o` rising, `timeout_o` pulses high for one cycle, `cnv_o` drops in that same cycle, and no result is produced.
- R8: Between a fall of `cnv_o` and its next rise, at least ACQ_CYC clock cycles pass.
- R9: `start` has no effect while a conversion or readback is in progress or while `m_valid` is high.
- R10: During readback, each half of the `sck_o` period lasts SCK_HALF clock cycles, so consecutive falling edges are 2*SCK_HALF cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion and readback cycle |
| sdo_in | input | 1 | Serial data from the nearest device in the chain |
| m_ready | input | 1 | User accepts the pending result |
| cnv_o | output | 1 | Shared convert strobe |
| sck_o | output | 1 | Shared serial clock, idles high |
| m_valid | output | 1 | Result set is valid |
| m_data | output | N_DEV*WORD_W | Concatenated words, nearest device in the top word |
| timeout_o | output | 1 | One-cycle pulse when the completion edge never came |

## Verification
The bench models the chain as one flag bit followed by the concatenated words, shifted on each falling serial clock edge. It sweeps all-zero, all-one, alternating and arithmetic word patterns over a range of conversion delays. A controller that kept the flag bit, or that issued 16N clocks instead of 16N+1, would return every word shifted by one bit and would show the wrong edge count. A data line already stuck high at start must end in a timeout rather than an instant readback, which exposes a design that tests the level instead of the edge. The bench holds `start` high through readback, through a held result and straight after acceptance, so a design that restarted early or skipped the acquisition gap would disturb the edge count, change the held data, or raise the strobe too soon.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

  // Sequencer states of the readback controller
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a start request
    ST_CONV = 2'd1,  // strobe high, waiting for the completion edge
    ST_READ = 2'd2,  // clocking the chain
    ST_ACQ  = 2'd3   // strobe low, acquisition interval running
  } rd_state_t;

endpackage

// File: rtl/chain_rd_sckgen.sv
// Serial clock generator: idles high, toggles every HALF cycles while run is set.
module chain_rd_sckgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck_q,
  output logic fall_now,
  output logic rise_now
);

  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] ph;
  logic          tick;

  assign tick     = run && (ph == PW'(HALF - 1));
  assign fall_now = tick && sck_q;
  assign rise_now = tick && !sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph    <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      ph    <= '0;
      sck_q <= ~sck_q;
    end else begin
      ph    <= ph + 1'b1;
    end
  end

endmodule

// File: rtl/chain_rd_shreg.sv
// Capture register: one bit enters at the bottom on each strobe, the oldest
// bit leaves at the top. One extra shift therefore drops the first bit.
module chain_rd_shreg #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], din};
    end
  end

endmodule

// File: rtl/chain_rd_count.sv
// Interval counter: counts enabled cycles from a clear and flags the
// LIMIT-th one.
module chain_rd_count #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign hit = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && !hit) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
  parameter int N_DEV       = 8,
  parameter int WORD_W      = 16,
  parameter int SCK_HALF    = 2,
  parameter int TIMEOUT_CYC = 4096,
  parameter int ACQ_CYC     = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      sdo_in,
  input  logic                      m_ready,
  output logic                      cnv_o,
  output logic                      sck_o,
  output logic                      m_valid,
  output logic [N_DEV*WORD_W-1:0]   m_data,
  output logic                      timeout_o
);

  import chain_rd_pkg::*;

  localparam int DATA_W = N_DEV * WORD_W;
  localparam int NCLK   = DATA_W + 1;          // flag bit plus all words
  localparam int BW     = $clog2(NCLK + 1);

  rd_state_t          st;
  logic               sdo_q;
  logic               sdo_rise;
  logic [BW-1:0]      nfall;
  logic               last_seen;
  logic               run;
  logic               sck_w;
  logic               fall_now;
  logic               rise_now;
  logic [DATA_W-1:0]  shq;
  logic               tmo_hit;
  logic               acq_hit;

  assign sdo_rise = sdo_in && !sdo_q;
  assign run      = (st == ST_READ);
  assign sck_o    = sck_w;

  chain_rd_sckgen #(
    .HALF (SCK_HALF)
  ) u_sck (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sck_q    (sck_w),
    .fall_now (fall_now),
    .rise_now (rise_now)
  );

  // Sample on the clock edge that drives sck low: the chain has not yet
  // moved to the next bit, so the value seen is the one before the fall.
  chain_rd_shreg #(
    .W (DATA_W)
  ) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (fall_now),
    .din      (sdo_in),
    .q        (shq)
  );

  chain_rd_count #(
    .LIMIT (TIMEOUT_CYC)
  ) u_tmo (
    .clk (clk),
    .rst (rst),
    .clr (st != ST_CONV),
    .en  ((st == ST_CONV) && !sdo_rise),
    .hit (tmo_hit)
  );

  chain_rd_count #(
    .LIMIT (ACQ_CYC)
  ) u_acq (
    .clk (clk),
    .rst (rst),
    .clr (st != ST_ACQ),
    .en  (st == ST_ACQ),
    .hit (acq_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnv_o     <= 1'b0;
      m_valid   <= 1'b0;
      m_data    <= '0;
      timeout_o <= 1'b0;
      sdo_q     <= 1'b0;
      nfall     <= '0;
      last_seen <= 1'b0;
    end else begin
      sdo_q     <= sdo_in;
      timeout_o <= 1'b0;
      if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
      case (st)
        ST_IDLE: begin
          if (start && !m_valid) begin
            cnv_o <= 1'b1;
            st    <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (sdo_rise) begin
            nfall     <= '0;
            last_seen <= 1'b0;
            st        <= ST_READ;
          end else if (tmo_hit) begin
            cnv_o     <= 1'b0;
            timeout_o <= 1'b1;
            st        <= ST_ACQ;
          end
        end
        ST_READ: begin
          if (fall_now) begin
            nfall <= nfall + 1'b1;
            if (nfall == BW'(NCLK - 1)) begin
              last_seen <= 1'b1;
            end
          end
          if (rise_now && last_seen) begin
            cnv_o   <= 1'b0;
            m_valid <= 1'b1;
            m_data  <= shq;
            st      <= ST_ACQ;
          end
        end
        ST_ACQ: begin
          if (acq_hit) begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chain_adc_reader_chk.sv
module chain_adc_reader_chk #(
  parameter int N_DEV       = 8,
  parameter int WORD_W      = 16,
  parameter int ACQ_CYC     = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cnv_o,
  input logic                    sck_o,
  input logic                    m_valid,
  input logic                    m_ready,
  input logic                    timeout_o,
  input logic [N_DEV*WORD_W-1:0] m_data
);

  localparam int NCLK = N_DEV * WORD_W + 1;
  localparam int BW   = $clog2(NCLK + 1);
  localparam int LW   = $clog2(ACQ_CYC + 1);

  logic          sck_d;
  logic [BW-1:0] fcnt;
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b1;
      fcnt   <= '0;
      lowcnt <= LW'(ACQ_CYC);
    end else begin
      sck_d <= sck_o;
      if (!cnv_o) begin
        fcnt <= '0;
      end else if (sck_d && !sck_o) begin
        fcnt <= fcnt + 1'b1;
      end
      if (cnv_o) begin
        lowcnt <= '0;
      end else if (lowcnt < LW'(ACQ_CYC)) begin
        lowcnt <= lowcnt + 1'b1;
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!cnv_o && sck_o && !m_valid && !timeout_o));

  // R2
  cnv_rise_sck_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> sck_o);

  // R3
  sck_low_under_cnv_chk: assert property (@(posedge clk) disable iff (rst)
    !sck_o |-> cnv_o);

  // R4
  edge_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cnv_o) && !timeout_o) |-> (fcnt == BW'(NCLK)));

  // R6
  valid_with_cnv_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $fell(cnv_o));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready) |=> !m_valid);

  // R7
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

  // R7
  timeout_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!cnv_o && !$rose(m_valid)));

  // R8
  acq_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> (lowcnt >= LW'(ACQ_CYC)));

endmodule

bind chain_adc_reader chain_adc_reader_chk #(
  .N_DEV   (N_DEV),
  .WORD_W  (WORD_W),
  .ACQ_CYC (ACQ_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnv_o     (cnv_o),
  .sck_o     (sck_o),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .timeout_o (timeout_o),
  .m_data    (m_data)
);

// File: tb/chain_adc_reader_tb.sv
`timescale 1ns/1ps
module chain_adc_reader_tb;

  localparam int N    = 3;
  localparam int W    = 16;
  localparam int HALF = 2;
  localparam int TMO  = 60;
  localparam int ACQ  = 10;
  localparam int DW   = N * W;
  localparam int NCLK = DW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          sdo_in;
  logic          m_ready = 1'b0;
  logic          cnv_o, sck_o, m_valid, timeout_o;
  logic [DW-1:0] m_data;

  chain_adc_reader #(
    .N_DEV (N), .WORD_W (W), .SCK_HALF (HALF),
    .TIMEOUT_CYC (TMO), .ACQ_CYC (ACQ)
  ) u_dut (
    .clk (clk), .rst (rst), .start (start), .sdo_in (sdo_in),
    .m_ready (m_ready), .cnv_o (cnv_o), .sck_o (sck_o),
    .m_valid (m_valid), .m_data (m_data), .timeout_o (timeout_o)
  );

  always #5 clk = ~clk;

  int     vec = 0;
  int     bad = 0;
  longint cyc = 0;
  bit     finished = 0;

  always @(posedge clk) cyc++;

  // chain model: flag bit then all words, advanced on each sck fall
  logic [NCLK-1:0] stream;
  int     conv_delay = 1;
  bit     stuck_hi = 0;
  logic   sdo_m = 1'b0;
  bit     reading = 0;
  int     pos = 0;
  int     falls = 0;
  int     per_bad = 0;
  longint last_fall = 0;
  int     sck_at_rise = 1;
  int     cnv_rises = 0;
  longint rise_cyc = 0;
  longint fall_cyc = 0;
  bit     have_fall = 0;
  longint last_gap = 1000;

  assign sdo_in = sdo_m | stuck_hi;

  always @(posedge cnv_o) begin
    cnv_rises++;
    rise_cyc    = cyc;
    sck_at_rise = sck_o;
    falls       = 0;
    if (have_fall) last_gap = cyc - fall_cyc;
    if (conv_delay > 0) begin
      repeat (conv_delay) @(posedge clk);
      #1;
      if (cnv_o) begin
        sdo_m   = 1'b1;
        pos     = NCLK - 1;
        reading = 1;
      end
    end
  end

  always @(negedge cnv_o) begin
    fall_cyc  = cyc;
    have_fall = 1;
    reading   = 0;
    sdo_m     = 1'b0;
  end

  always @(negedge sck_o) begin
    falls++;
    if (falls > 1 && (cyc - last_fall) != 2 * HALF) per_bad++;
    last_fall = cyc;
    if (reading) begin
      #1;
      pos--;
      sdo_m = (pos >= 0) ? stream[pos] : 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat_word(input int p, input int k);
    logic [W-1:0] v;
    if (p == 0)      v = '0;
    else if (p == 1) v = '1;
    else if (p == 2) v = (k % 2 == 0) ? 16'hAAAA : 16'h5555;
    else if (p == 3) v = 16'h8001 >> k;
    else             v = W'((p * 15133 + k * 7989 + 199) ^ (k << p));
    return v;
  endfunction

  // raise start and keep it up until the strobe rises (or a limit)
  task automatic fire();
    int n;
    n = 0;
    @(negedge clk) start = 1'b1;
    while (!cnv_o && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic do_cycle(input int p, input int delay, input int hold);
    logic [DW-1:0] exp;
    logic [DW-1:0] held;
    int n;
    int rises0;
    for (int k = 0; k < N; k++) exp[W*(N-k)-1 -: W] = pat_word(p, k);
    stream     = {1'b1, exp};
    conv_delay = delay;
    per_bad    = 0;
    fire();
    n = 0;
    while (!m_valid && n < 3000) begin @(negedge clk); n++; end
    check(m_valid == 1'b1, "R6", "result valid", m_valid, 1);
    // R5 data order and flag drop
    check(m_data == exp, "R5", "words", m_data, exp);
    // R4 flag bit plus every data bit
    check(falls == NCLK, "R4", "sck falls", falls, NCLK);
    // R2 strobe rose with sck high
    check(sck_at_rise == 1, "R2", "sck at cnv rise", sck_at_rise, 1);
    // R10 serial clock period
    check(per_bad == 0, "R10", "fall spacing errors", per_bad, 0);
    // R3 strobe stayed high through conversion and readback
    check((fall_cyc - rise_cyc) >= longint'(delay + 2 * HALF * NCLK), "R3",
          "cnv high cycles", fall_cyc - rise_cyc, delay + 2 * HALF * NCLK);
    check(cnv_o == 1'b0, "R3", "cnv low after readback", cnv_o, 0);
    // R8 gap before this strobe rise
    check(last_gap >= ACQ, "R8", "acquisition gap", last_gap, ACQ);
    // R6 / R9 result held while start keeps requesting
    held   = m_data;
    rises0 = cnv_rises;
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      check(m_valid == 1'b1 && m_data == held, "R6", "held result", m_data, held);
      check(cnv_rises == rises0, "R9", "strobe rises while pending",
            cnv_rises, rises0);
    end
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    check(m_valid == 1'b0, "R6", "valid after handshake", m_valid, 0);
  endtask

  task automatic do_timeout(input bit stuck, input int delay);
    int n;
    stuck_hi   = stuck;
    conv_delay = delay;
    fire();
    start = 1'b0;
    n = 0;
    while (!timeout_o && n < TMO + 40) begin @(negedge clk); n++; end
    check(timeout_o == 1'b1, "R7", "timeout seen", timeout_o, 1);
    check(n >= TMO - 1 && n <= TMO + 1, "R7", "cycles to timeout", n, TMO);
    check(cnv_o == 1'b0 && m_valid == 1'b0, "R7", "no result, cnv low",
          {cnv_o, m_valid}, 0);
    @(negedge clk);
    check(timeout_o == 1'b0, "R7", "timeout one cycle", timeout_o, 0);
    stuck_hi   = 0;
    conv_delay = 1;
    repeat (ACQ + 5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnv_o == 0 && sck_o == 1 && m_valid == 0 && timeout_o == 0, "R1",
          "outputs in reset", {cnv_o, sck_o, m_valid, timeout_o}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    check(cnv_o == 0 && sck_o == 1 && m_valid == 0, "R1", "after release",
          {cnv_o, sck_o, m_valid}, 3'b010);
    // R9 idle without start: nothing happens
    repeat (20) @(negedge clk);
    check(cnv_rises == 0, "R9", "no strobe without start", cnv_rises, 0);
    // pattern sweep over several conversion delays; start stays high
    for (int p = 0; p < 14; p++) begin
      do_cycle(p, 1 + (p * 7) % 45, (p % 3 == 0) ? 15 : 0);
    end
    start = 1'b0;
    // R7 no completion edge, and a data line stuck high
    do_timeout(1'b0, 0);
    do_timeout(1'b1, 0);
    do_timeout(1'b0, TMO + 20);
    // recovery after timeouts
    do_cycle(5, 3, 4);
    do_cycle(1, 2, 0);
    start = 1'b0;
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vec++;
      bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule